// File: doc/BRIEF.md
# Bytewide Timekeeper and SRAM Access Decoder

This block sits between a processor's asynchronous byte-wide memory bus and two targets: a bank of sixteen timekeeper registers inside the chip, and an external static RAM. A single flat 19-bit address space is split so that the sixteen highest addresses always reach the internal registers, whatever RAM size is fitted. Every other address goes straight to the external RAM. The external RAM's chip-enable and output-enable strobes are derived from the bus strobes. The RAM's output enable is held off whenever a register address is on the bus, so the two sources never fight for the data lines.

Register reads are combinational. The block presents a 4-bit register index to the bank and drives the bank's byte onto the data bus through a tri-state enable. A register write is the interval in which chip enable and write enable are both low. The block samples the address and data on every clock while that interval lasts. When the interval ends, it issues a one-clock write pulse with the index and byte from the last sample. A write-protect input from the power supervisor forces the external RAM deselected and blocks register reads and writes.

Top module: `rtc_bus_decoder`

## Requirements
- R1: An address hits the register window when its upper 15 bits are all ones (0x7FFF0 to 0x7FFFF). `reg_rd_idx` always equals address bits [3:0].
- R2: `ram_ce_n` follows `bus_ce_n` while `wr_protect` is low. It is 1 whenever `wr_protect` is 1.
- R3: `ram_oe_n` is 1 whenever the address hits the register window, whatever the other strobes are.
- R4: Outside the register window, `ram_oe_n` equals `bus_oe_n`.
- R5: `bus_doe` is 1 exactly when all of the following hold: `bus_ce_n`=0, `bus_oe_n`=0, `bus_we_n`=1, the address hits the window, and `wr_protect`=0. `bus_dout` equals `reg_rd_data`.
- R6: Pulling `bus_we_n` low during a register read drops `bus_doe` in the same cycle.
- R7: A write lasts while `bus_ce_n` and `bus_we_n` are both low. At the first clock edge that samples it inactive, `reg_wr_stb` rises for exactly one cycle. `reg_wr_idx` and `reg_wr_data` then hold address bits [3:0] and `bus_din` as sampled at the last edge where the write was active.
- R8: A write starts when the later of the two strobes falls and ends when the earlier rises. `bus_we_n` toggling while `bus_ce_n` is high, or `bus_ce_n` toggling while `bus_we_n` is high, produces no write pulse.
- R9: A write whose last active sample has an address outside the register window produces no write pulse.
- R10: A write whose last active sample has `wr_protect`=1 produces no write pulse. While `wr_protect` is 1, `bus_doe` stays 0.
- R11: After synchronous reset, `reg_wr_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 19 | Bus address |
| bus_ce_n | input | 1 | Bus chip enable, active low |
| bus_we_n | input | 1 | Bus write enable, active low |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_din | input | 8 | Write data from the bus |
| bus_dout | output | 8 | Register read data toward the bus |
| bus_doe | output | 1 | Tri-state enable for `bus_dout` |
| wr_protect | input | 1 | Supervisor write protect, active high |
| ram_ce_n | output | 1 | External RAM chip enable, active low |
| ram_oe_n | output | 1 | External RAM output enable, active low |
| reg_rd_idx | output | 4 | Register index for reads |
| reg_rd_data | input | 8 | Byte from the register bank |
| reg_wr_stb | output | 1 | One-cycle register write pulse |
| reg_wr_idx | output | 4 | Register index for the write |
| reg_wr_data | output | 8 | Byte for the write |

## Verification
The RAM strobes, read index, data enable and read data are combinational. The bench therefore compares them in the same cycle as the stimulus, at the falling edge after the inputs change. The write pulse comes from one register stage behind the sampled strobes. The reference model advances on every rising edge, and the pulse, index and data are compared at the falling edge right after the first edge that sees the write inactive. Directed cases cover both ways a write can end, strobes toggling alone, writes outside the window and under protect, and a write-enable fall in the middle of a read. A long pseudo-random run then exercises all of these together.

// File: rtl/rtcdec_pkg.sv
// Shared sizes and types for the bytewide timekeeper/SRAM decoder.
// Assumes a byte-wide bus. The register window sits at the top of the space.
package rtcdec_pkg;
    localparam int ADDR_W = 19;
    localparam int IDX_W  = 4;
    localparam int DATA_W = 8;

    // Active-low bus strobes, kept together as one bundle.
    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } bus_strb_t;
endpackage

// File: rtl/rtcdec_addr_window.sv
// Address window compare.
// Flags addresses that fall in the 2**IDX_W-byte register window and extracts
// the register index. WIN_AT_TOP picks whether the window is the highest
// (1) or the lowest (0) block of the address space.
module rtcdec_addr_window #(
    parameter int ADDR_W     = 19,
    parameter int IDX_W      = 4,
    parameter bit WIN_AT_TOP = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [TAG_W-1:0] tag;
    assign tag = addr[ADDR_W-1:IDX_W];
    assign idx = addr[IDX_W-1:0];

    generate
        if (WIN_AT_TOP) begin : g_top
            // Window is the block whose tag bits are all ones.
            assign hit = &tag;
        end else begin : g_bottom
            // Window is the block whose tag bits are all zeros.
            assign hit = ~|tag;
        end
    endgenerate
endmodule

// File: rtl/rtcdec_strobe_gate.sv
// Strobe gating.
// Derives the external RAM strobes, the register read enable and the
// write-active level from the bus strobes, the window hit and write protect.
// Purely combinational; assumes the strobes are glitch-free at the pins.
module rtcdec_strobe_gate
    import rtcdec_pkg::*;
(
    input  bus_strb_t strb,
    input  logic      hit,
    input  logic      wr_protect,
    output logic      ram_ce_n,
    output logic      ram_oe_n,
    output logic      rd_en,
    output logic      wr_act
);
    // RAM chip enable: pass through unless the supervisor protects.
    always_comb ram_ce_n = strb.ce_n | wr_protect;

    // RAM output enable: suppressed for register addresses.
    always_comb ram_oe_n = strb.oe_n | hit;

    // Register read: selected, output enabled, not writing, unprotected.
    always_comb rd_en = ~strb.ce_n & ~strb.oe_n & strb.we_n & hit & ~wr_protect;

    // Write interval: both chip enable and write enable low.
    always_comb wr_act = ~strb.ce_n & ~strb.we_n;
endmodule

// File: rtl/rtcdec_wr_capture.sv
// Register write capture.
// Samples index, data and qualification on every clock while the write
// interval lasts. When the interval ends, it emits a one-cycle strobe with
// the last sample. Assumes the strobes are synchronous to clk, or brought
// into clk's domain upstream.
module rtcdec_wr_capture #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_act,
    input  logic              wr_ok,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] din,
    output logic              wr_stb,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);
    logic              act_q;
    logic              ok_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] data_q;
    logic              wr_end;

    // End of a write: active at the last edge, inactive now.
    always_comb wr_end = act_q & ~wr_act;

    // Track the write interval and keep its latest sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            ok_q   <= 1'b0;
            idx_q  <= '0;
            data_q <= '0;
        end else begin
            act_q <= wr_act;
            if (wr_act) begin
                ok_q   <= wr_ok;
                idx_q  <= idx;
                data_q <= din;
            end
        end
    end

    // Emit the qualified one-cycle write pulse with its payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= wr_end & ok_q;
            if (wr_end) begin
                wr_idx  <= idx_q;
                wr_data <= data_q;
            end
        end
    end
endmodule

// File: rtl/rtc_bus_decoder.sv
// Bytewide timekeeper / external SRAM access decoder (top).
// Splits the flat bus address space. The top 2**IDX_W bytes go to the
// internal register bank; everything else goes to an external RAM.
// Register reads are combinational; register writes are posted as
// a one-cycle pulse after the bus write ends.
module rtc_bus_decoder
    import rtcdec_pkg::*;
#(
    parameter int ADDR_W = rtcdec_pkg::ADDR_W,
    parameter int IDX_W  = rtcdec_pkg::IDX_W,
    parameter int DATA_W = rtcdec_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic              wr_protect,
    output logic              ram_ce_n,
    output logic              ram_oe_n,
    output logic [IDX_W-1:0]  reg_rd_idx,
    input  logic [DATA_W-1:0] reg_rd_data,
    output logic              reg_wr_stb,
    output logic [IDX_W-1:0]  reg_wr_idx,
    output logic [DATA_W-1:0] reg_wr_data
);
    bus_strb_t        strb;
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             wr_act;
    logic             wr_ok;

    // Bundle the bus strobes.
    always_comb strb = '{ce_n: bus_ce_n, we_n: bus_we_n, oe_n: bus_oe_n};

    rtcdec_addr_window #(
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W),
        .WIN_AT_TOP(1'b1)
    ) u_win (
        .addr(bus_addr),
        .hit (hit),
        .idx (idx)
    );

    rtcdec_strobe_gate u_gate (
        .strb      (strb),
        .hit       (hit),
        .wr_protect(wr_protect),
        .ram_ce_n  (ram_ce_n),
        .ram_oe_n  (ram_oe_n),
        .rd_en     (bus_doe),
        .wr_act    (wr_act)
    );

    // A write counts only in the window and while unprotected.
    always_comb wr_ok = hit & ~wr_protect;

    rtcdec_wr_capture #(
        .IDX_W (IDX_W),
        .DATA_W(DATA_W)
    ) u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_act (wr_act),
        .wr_ok  (wr_ok),
        .idx    (idx),
        .din    (bus_din),
        .wr_stb (reg_wr_stb),
        .wr_idx (reg_wr_idx),
        .wr_data(reg_wr_data)
    );

    // Read path: index straight out, bank data straight back.
    assign reg_rd_idx = idx;
    assign bus_dout   = reg_rd_data;
endmodule

// File: rtl/rtc_bus_decoder_chk.sv
// Assertion checker for rtc_bus_decoder, bound to every instance.
// Works only from the top-level ports.
module rtc_bus_decoder_chk #(
    parameter int ADDR_W = 19,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ce_n,
    input logic              bus_we_n,
    input logic              bus_oe_n,
    input logic              wr_protect,
    input logic              ram_ce_n,
    input logic              ram_oe_n,
    input logic              bus_doe,
    input logic              reg_wr_stb
);
    logic in_win;
    assign in_win = &bus_addr[ADDR_W-1:IDX_W];

    // R2: protect deselects the external RAM.
    p_protect_ram_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_protect |-> ram_ce_n);

    // R3: no RAM output enable for register addresses.
    p_win_oe_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |-> ram_oe_n);

    // R4: output enable passes through outside the window.
    p_oe_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |-> (ram_oe_n == bus_oe_n));

    // R5 and R6: data is driven only in a qualified register read.
    p_doe_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> (!bus_ce_n && !bus_oe_n && bus_we_n && in_win));

    // R10: protect blocks the data drivers.
    p_protect_doe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_protect |-> !bus_doe);

    // R7: the write pulse lasts one cycle.
    p_stb_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_stb |=> !reg_wr_stb);

    // R8: a pulse follows a cycle in which both strobes were low.
    p_stb_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_stb |-> $past(!bus_ce_n && !bus_we_n, 2));
endmodule

bind rtc_bus_decoder rtc_bus_decoder_chk #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_ce_n  (bus_ce_n),
    .bus_we_n  (bus_we_n),
    .bus_oe_n  (bus_oe_n),
    .wr_protect(wr_protect),
    .ram_ce_n  (ram_ce_n),
    .ram_oe_n  (ram_oe_n),
    .bus_doe   (bus_doe),
    .reg_wr_stb(reg_wr_stb)
);

// File: tb/tb_rtc_bus_decoder.sv
`timescale 1ns/1ps
module tb_rtc_bus_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] addr = '0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wp = 1'b0;
    logic [7:0]  din = '0;
    logic [7:0]  dout, rd_data, wr_data;
    logic        doe, ram_ce_n, ram_oe_n, wr_stb;
    logic [3:0]  rd_idx, wr_idx;

    int    vectors = 0;
    int    fails = 0;
    bit    started = 1'b0;
    string stb_tag = "R7";

    // Reference model state.
    bit       m_prev = 0, m_ok = 0, e_stb = 0;
    bit [3:0] m_idx = 0, e_idx = 0;
    bit [7:0] m_data = 0, e_data = 0;

    always #2.5 clk = ~clk;

    // Register bank stand-in: a fixed function of the index.
    assign rd_data = {4'h5, rd_idx} ^ 8'h3C;

    rtc_bus_decoder dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_ce_n(ce_n),
        .bus_we_n(we_n), .bus_oe_n(oe_n), .bus_din(din), .bus_dout(dout),
        .bus_doe(doe), .wr_protect(wp), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n),
        .reg_rd_idx(rd_idx), .reg_rd_data(rd_data), .reg_wr_stb(wr_stb),
        .reg_wr_idx(wr_idx), .reg_wr_data(wr_data)
    );

    function automatic bit in_win(logic [18:0] a);
        return a >= 19'h7FFF0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model of the write pulse, advanced on every rising edge.
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            m_prev = 0; m_ok = 0; e_stb = 0;
        end else begin
            bit act;
            act   = !ce_n && !we_n;
            e_stb = m_prev && !act && m_ok;
            if (e_stb) begin e_idx = m_idx; e_data = m_data; end
            if (act) begin
                m_idx = addr[3:0]; m_data = din; m_ok = in_win(addr) && !wp;
            end
            m_prev = act;
        end
    end

    // Compare everything at the falling edge.
    always @(negedge clk) begin
        if (started) begin
            if (!rst_n) begin
                chk("R11 reset strobe", wr_stb, 0);
            end else begin
                bit h, exp_doe;
                h = in_win(addr);
                exp_doe = !ce_n && !oe_n && we_n && h && !wp;
                chk("R1 read index", rd_idx, addr[3:0]);
                chk("R2 ram_ce_n", ram_ce_n, ce_n | wp);
                chk(h ? "R3 ram_oe_n in window" : "R4 ram_oe_n passthrough",
                    ram_oe_n, h ? 1 : oe_n);
                chk(wp ? "R10 doe under protect" : (!we_n ? "R6 doe with write low" : "R5 doe"),
                    doe, exp_doe);
                if (exp_doe) chk("R5 read data", dout, {4'h5, addr[3:0]} ^ 8'h3C);
                chk(stb_tag, wr_stb, e_stb);
                if (e_stb) begin
                    chk("R7 write index", wr_idx, e_idx);
                    chk("R7 write data", wr_data, e_data);
                end
            end
        end
    end

    task automatic drv(logic [18:0] a, logic c, logic w, logic o, logic [7:0] d, logic p);
        @(posedge clk); #1;
        addr = a; ce_n = c; we_n = w; oe_n = o; din = d; wp = p;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drv(addr, 1, 1, 1, din, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1, R3, R5: register reads across the window.
        for (int i = 0; i < 16; i++) drv(19'h7FFF0 + i, 0, 1, 0, 0, 0);
        // R4: reads outside the window, including the byte just below it.
        drv(19'h7FFEF, 0, 1, 0, 0, 0);
        drv(19'h00000, 0, 1, 0, 0, 0);
        drv(19'h3FFFF, 0, 1, 1, 0, 0);
        // R6: write enable falls during a register read.
        drv(19'h7FFF4, 0, 1, 0, 0, 0);
        stb_tag = "R7";
        drv(19'h7FFF4, 0, 0, 0, 8'h99, 0);
        drv(19'h7FFF4, 0, 1, 0, 0, 0);
        idle(2);
        // R7: write terminated by write enable; data changes before the end.
        drv(19'h7FFF9, 0, 0, 1, 8'h11, 0);
        drv(19'h7FFF9, 0, 0, 1, 8'hA7, 0);
        drv(19'h7FFF9, 0, 1, 1, 8'h00, 0);
        idle(2);
        // R7: write terminated by chip enable.
        drv(19'h7FFFE, 1, 0, 1, 8'h5A, 0);
        drv(19'h7FFFE, 0, 0, 1, 8'h5A, 0);
        drv(19'h7FFFE, 1, 0, 1, 8'h00, 0);
        idle(2);
        // R8: strobes toggling alone give no write.
        stb_tag = "R8";
        drv(19'h7FFF2, 1, 0, 1, 8'h33, 0);
        drv(19'h7FFF2, 1, 1, 1, 8'h33, 0);
        drv(19'h7FFF2, 0, 1, 1, 8'h33, 0);
        drv(19'h7FFF2, 1, 1, 1, 8'h33, 0);
        idle(2);
        // R9: write outside the window.
        stb_tag = "R9";
        drv(19'h12345, 0, 0, 1, 8'h44, 0);
        drv(19'h12345, 1, 1, 1, 8'h44, 0);
        idle(2);
        // R10 and R2: protected write and read.
        stb_tag = "R10";
        drv(19'h7FFF3, 0, 0, 1, 8'h66, 1);
        drv(19'h7FFF3, 1, 1, 1, 8'h66, 1);
        drv(19'h7FFF3, 0, 1, 0, 8'h00, 1);
        drv(19'h00100, 0, 1, 0, 8'h00, 1);
        idle(2);
        // Back-to-back writes with a one-cycle gap.
        stb_tag = "R7";
        drv(19'h7FFF1, 0, 0, 1, 8'hC1, 0);
        drv(19'h7FFF1, 0, 1, 1, 8'h00, 0);
        drv(19'h7FFF7, 0, 0, 1, 8'hC7, 0);
        drv(19'h7FFF7, 1, 1, 1, 8'h00, 0);
        idle(2);
        // Mixed pseudo-random traffic, checked against the model.
        stb_tag = "R7/R9/R10 random";
        for (int i = 0; i < 3000; i++) begin
            logic [18:0] a;
            a = $urandom_range(0, 1) ? (19'h7FFF0 | 19'($urandom_range(0, 15)))
                                     : 19'($urandom);
            drv(a, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 0,
                $urandom_range(0, 1) == 0, 8'($urandom), $urandom_range(0, 7) == 0);
        end
        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R7: watchdog expired, actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule